// File: doc/BRIEF.md
# JESD204B Transmit Transport Framer

The framer sits between the sample sources of a converter datapath and a multi-lane JESD204B transmit link layer. On every data-clock cycle it takes a group of samples from each of M converters (DPW samples per converter, NP bits each). It rearranges their octets into frames of F octets per lane and hands the link layer one 32-bit word per lane. One lane word always carries a whole number of frames (four, two or one for F of 1, 2 or 4). The number of samples each converter supplies per cycle follows from the lane count: DPW = L*32/(M*NP).

The configuration is fixed by the parameters L (lanes), M (converters), F (octets per frame per lane), S (samples per converter per frame) and NP (bits per sample). An inconsistent set stops elaboration. A single output register decouples the two sides with a valid/ready handshake. While the link side stalls, the register holds its beat and the sample side is refused.

Top module: `tx_transport_framer`

## Requirements
- R1: Elaboration accepts only F in {1,2,4}, NP in {8,16}, M*S*NP = L*F*8 and a whole DPW = L*32/(M*NP). The sample input is M*DPW*NP bits wide and the lane output is L*32 bits wide.
- R2: While rst_n is low, lane_data is all zero, lane_valid is 0 and s_ready is 0. s_ready rises within three clock cycles after rst_n is released.
- R3: Within one frame, samples are taken converter 0 first. Within a converter they are taken in increasing sample index, and each sample most significant octet first. Octet number k of this sequence goes to lane k mod L, at frame octet position k div L.
- R4: A lane word holds 4/F frames. Frame j occupies byte j*F+p of each lane word, where byte b is bits 8b+7..8b and p is the frame octet position. Frame j is built from samples j*S to j*S+S-1 of every converter.
- R5: Converter c occupies input bits c*DPW*NP upward. Its sample n sits at bits n*NP upward within that slice, so sample 0, the earliest, is the least significant.
- R6: A beat accepted at a clock edge (s_valid and s_ready both high) appears on lane_data with lane_valid high immediately after that edge.
- R7: While lane_valid is high and link_ready is low, s_ready is low. lane_data and lane_valid are unchanged after the next edge.
- R8: When a beat is consumed (lane_valid and link_ready high) and no new beat is accepted at that edge, lane_valid is low after it.
- R9: With link_ready held high, a beat is accepted on every cycle with no gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Data clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid | input | 1 | Sample group present |
| s_ready | output | 1 | Framer can take a sample group |
| s_data | input | M*DPW*NP | Samples of all converters for one cycle |
| link_ready | input | 1 | Link layer takes the current beat |
| lane_valid | output | 1 | lane_data holds a beat |
| lane_data | output | L*32 | One 32-bit word per lane, lane l at bits 32l upward |

## Verification
The bench goes after octet placement. A framer that swapped octet significance, placed converters in the wrong order, or advanced lanes before frame octets would misplace bytes against the independent frame-stream model. A directed pattern with distinct octets pins down each byte position exactly. Reversing the frame order inside a lane word would show up as swapped byte pairs. Under random stalls, a design that let the held beat change or kept accepting data would corrupt or lose scoreboard entries. A valid flag that failed to drop after the final beat would appear as a phantom transfer during drain.

// File: rtl/txf_pkg.sv
package txf_pkg;

  typedef logic [7:0] octet_t;

  localparam int LANE_BITS = 32;
  localparam int LANE_OCTETS = LANE_BITS / 8;

  function automatic bit cfg_ok(input int l, input int m, input int f,
                                input int s, input int np);
    bit ok;
    ok = (f == 1 || f == 2 || f == 4) && (np == 8 || np == 16);
    ok = ok && (l > 0) && (m > 0) && (s > 0);
    ok = ok && (m * s * np == l * f * 8);
    ok = ok && (((l * LANE_BITS) % (m * np)) == 0);
    return ok;
  endfunction

  function automatic int samples_per_beat(input int l, input int m, input int np);
    return (l * LANE_BITS) / (m * np);
  endfunction

endpackage

// File: rtl/txf_rst_sync.sv
module txf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= stage_d;
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/txf_octet_map.sv
module txf_octet_map #(
  parameter int L  = 4,
  parameter int M  = 4,
  parameter int F  = 2,
  parameter int S  = 1,
  parameter int NP = 16,
  localparam int DPW   = txf_pkg::samples_per_beat(L, M, NP),
  localparam int IN_W  = M * DPW * NP,
  localparam int OUT_W = L * txf_pkg::LANE_BITS
) (
  input  logic [IN_W-1:0]  smp,
  output logic [OUT_W-1:0] lanes
);
  // Pure wiring: each output byte is one octet of one input sample.
  for (genvar ln = 0; ln < L; ln++) begin : g_lane
    for (genvar by = 0; by < txf_pkg::LANE_OCTETS; by++) begin : g_byte
      localparam int FRM   = by / F;
      localparam int POS   = by % F;
      localparam int SEQ   = POS * L + ln;
      localparam int SIDX  = (SEQ * 8) / NP;
      localparam int HI    = ((SEQ * 8) % NP) / 8;
      localparam int CONV  = SIDX / S;
      localparam int SUB   = SIDX % S;
      localparam int BASE  = CONV * DPW * NP + (FRM * S + SUB) * NP;
      localparam int LO    = BASE + NP - 8 - HI * 8;
      assign lanes[ln*txf_pkg::LANE_BITS + by*8 +: 8] = smp[LO +: 8];
    end
  end
endmodule

// File: rtl/txf_flow.sv
module txf_flow (
  input  logic clk,
  input  logic rst_n,
  input  logic s_valid,
  input  logic link_ready,
  output logic s_ready,
  output logic load,
  output logic out_valid
);
  logic vld_q;
  logic vld_d;

  always_comb begin
    s_ready = rst_n && (!vld_q || link_ready);
    load    = s_valid && s_ready;
    vld_d   = vld_q;
    if (load)            vld_d = 1'b1;
    else if (link_ready) vld_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  assign out_valid = vld_q;
endmodule

// File: rtl/txf_beat_reg.sv
module txf_beat_reg #(
  parameter int W = 128
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_r;
  logic [W-1:0] q_n;

  always_comb begin
    q_n = q_r;
    if (en) q_n = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '0;
    else        q_r <= q_n;
  end

  assign q = q_r;
endmodule

// File: rtl/tx_transport_framer.sv
module tx_transport_framer #(
  parameter int L  = 4,
  parameter int M  = 4,
  parameter int F  = 2,
  parameter int S  = 1,
  parameter int NP = 16,
  localparam int DPW   = txf_pkg::samples_per_beat(L, M, NP),
  localparam int IN_W  = M * DPW * NP,
  localparam int OUT_W = L * txf_pkg::LANE_BITS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic [IN_W-1:0]  s_data,
  input  logic             link_ready,
  output logic             lane_valid,
  output logic [OUT_W-1:0] lane_data
);
  logic             rst_sync_n;
  logic             load;
  logic [OUT_W-1:0] mapped;

  if (!txf_pkg::cfg_ok(L, M, F, S, NP)) begin : g_bad_cfg
    $error("tx_transport_framer: inconsistent L/M/F/S/NP configuration");
  end

  txf_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  txf_octet_map #(.L(L), .M(M), .F(F), .S(S), .NP(NP)) u_map (
    .smp   (s_data),
    .lanes (mapped)
  );

  txf_flow u_flow (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .s_valid    (s_valid),
    .link_ready (link_ready),
    .s_ready    (s_ready),
    .load       (load),
    .out_valid  (lane_valid)
  );

  txf_beat_reg #(.W(OUT_W)) u_beat (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .en    (load),
    .d     (mapped),
    .q     (lane_data)
  );
endmodule

// File: rtl/txf_chk.sv
module txf_chk #(
  parameter int IN_W  = 128,
  parameter int OUT_W = 128
) (
  input logic             clk,
  input logic             rst_n,
  input logic             s_valid,
  input logic             s_ready,
  input logic [IN_W-1:0]  s_data,
  input logic             link_ready,
  input logic             lane_valid,
  input logic [OUT_W-1:0] lane_data
);
  // R2
  reset_zero_chk: assert property (@(posedge clk)
    !rst_n |-> (lane_data == '0 && !lane_valid && !s_ready));

  // R6
  accept_shows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> lane_valid);

  // R7
  stall_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_valid && !link_ready) |-> !s_ready);

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_valid && !link_ready) |=> (lane_valid && $stable(lane_data)));

  // R8
  drain_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_valid && link_ready && !(s_valid && s_ready)) |=> !lane_valid);

  // R9
  flow_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_valid && link_ready) |-> s_ready);
endmodule

bind tx_transport_framer txf_chk #(.IN_W(IN_W), .OUT_W(OUT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .s_valid    (s_valid),
  .s_ready    (s_ready),
  .s_data     (s_data),
  .link_ready (link_ready),
  .lane_valid (lane_valid),
  .lane_data  (lane_data)
);

// File: tb/sim_tx_transport_framer.sv
module sim_tx_transport_framer;
  localparam int L  = 4;
  localparam int M  = 4;
  localparam int F  = 2;
  localparam int S  = 1;
  localparam int NP = 16;
  localparam int DPW   = (L * 32) / (M * NP);
  localparam int FPB   = 4 / F;
  localparam int IN_W  = M * DPW * NP;
  localparam int OUT_W = L * 32;
  localparam int FB    = M * S * NP;

  logic             clk;
  logic             rst_n;
  logic             s_valid;
  logic             s_ready;
  logic [IN_W-1:0]  s_data;
  logic             link_ready;
  logic             lane_valid;
  logic [OUT_W-1:0] lane_data;

  int errors = 0;
  int checks = 0;
  int rdy_mode = 0;
  logic [OUT_W-1:0] sb_q[$];
  bit gap_seen;
  bit done = 0;

  tx_transport_framer #(.L(L), .M(M), .F(F), .S(S), .NP(NP)) u0 (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .link_ready(link_ready), .lane_valid(lane_valid),
    .lane_data(lane_data)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req,
                       input logic [OUT_W-1:0] act, input logic [OUT_W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Independent model: build the frame as a serial bit stream, then cut octets.
  function automatic logic [OUT_W-1:0] ref_beat(input logic [IN_W-1:0] d);
    logic [OUT_W-1:0] r;
    logic [FB-1:0] st;
    logic [7:0] oc;
    int pos;
    r = '0;
    for (int j = 0; j < FPB; j++) begin
      pos = 0;
      for (int c = 0; c < M; c++)
        for (int s = 0; s < S; s++)
          for (int bt = NP - 1; bt >= 0; bt--) begin
            st[pos] = d[c*DPW*NP + (j*S + s)*NP + bt];
            pos++;
          end
      for (int k = 0; k < L * F; k++) begin
        for (int i = 0; i < 8; i++) oc[7-i] = st[k*8 + i];
        r[(k % L)*32 + (j*F + k / L)*8 +: 8] = oc;
      end
    end
    return r;
  endfunction

  function automatic logic [IN_W-1:0] rand_data();
    logic [IN_W-1:0] v;
    for (int i = 0; i < IN_W; i += 32) v[i +: 32] = $urandom();
    return v;
  endfunction

  // Driver: present a beat, push expectation at the negedge before acceptance.
  task automatic send_beat(input logic [IN_W-1:0] d);
    s_data  = d;
    s_valid = 1'b1;
    gap_seen = 1'b0;
    forever begin
      @(negedge clk);
      if (s_ready) break;
      gap_seen = 1'b1;
    end
    sb_q.push_back(ref_beat(d));
    @(posedge clk);
    #1;
  endtask

  always @(posedge clk) begin
    #1;
    case (rdy_mode)
      0: link_ready = 1'b1;
      1: link_ready = ($urandom_range(0, 3) != 0);
      default: link_ready = 1'b0;
    endcase
  end

  // Monitor: scoreboard pops, stall and drain tracking.
  logic [OUT_W-1:0] held;
  bit stall_pend = 0;
  bit drain_pend = 0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (stall_pend) begin
        // R7 held beat unchanged
        check(lane_valid && lane_data == held, "R7 hold", lane_data, held);
        stall_pend = 0;
      end
      if (drain_pend) begin
        // R8 valid drops after last beat consumed
        check(!lane_valid, "R8 drain", {{(OUT_W-1){1'b0}}, lane_valid}, '0);
        drain_pend = 0;
      end
      if (lane_valid && link_ready) begin
        if (sb_q.size() == 0) begin
          check(1'b0, "R6 unexpected beat", lane_data, '0);
        end else begin
          logic [OUT_W-1:0] e;
          e = sb_q.pop_front();
          // R3 R4 R5 R6 scoreboard compare
          check(lane_data == e, "R3/R4/R5 data", lane_data, e);
        end
        if (!(s_valid && s_ready)) drain_pend = 1;
      end
      if (lane_valid && !link_ready) begin
        // R7 input refused while stalled
        check(!s_ready, "R7 refuse", {{(OUT_W-1){1'b0}}, s_ready}, '0);
        held = lane_data;
        stall_pend = 1;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [IN_W-1:0] dv;
    logic [OUT_W-1:0] dexp;
    rst_n = 1'b0;
    s_valid = 1'b0;
    s_data = '0;
    link_ready = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    // R2 reset state
    check(lane_data == '0, "R2 lanes", lane_data, '0);
    check(!lane_valid && !s_ready, "R2 flags", {{(OUT_W-2){1'b0}}, lane_valid, s_ready}, '0);
    // R1 port widths
    check($bits(s_data) == M*DPW*NP && $bits(lane_data) == L*32, "R1 widths",
          OUT_W'($bits(s_data)), OUT_W'(M*DPW*NP));
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    // R2 ready after release
    check(s_ready, "R2 release", {{(OUT_W-1){1'b0}}, s_ready}, 1);

    // Directed pattern: conv c sample n = {c*16+n, 0x80+c*16+n}
    if (L == 4 && M == 4 && F == 2 && S == 1 && NP == 16) begin
      for (int c = 0; c < M; c++)
        for (int n = 0; n < DPW; n++)
          dv[c*DPW*NP + n*NP +: 16] = {8'(c*16 + n), 8'(8'h80 + c*16 + n)};
      dexp = {32'hB191B090, 32'h31113010, 32'hA181A080, 32'h21012000};
      send_beat(dv);
      s_valid = 1'b0;
      @(negedge clk);
      // R3 R4 R5 R6 exact byte placement, one cycle after acceptance
      check(lane_valid && lane_data == dexp, "R3/R4/R5 directed", lane_data, dexp);
      @(posedge clk);
      #1;
    end

    // Back-to-back with link always ready
    for (int i = 0; i < 60; i++) begin
      send_beat(rand_data());
      // R9 no gap
      check(!gap_seen, "R9 gap", {{(OUT_W-1){1'b0}}, gap_seen}, '0);
    end
    s_valid = 1'b0;
    repeat (2) @(posedge clk);
    #1;

    // Random stalls and gaps
    rdy_mode = 1;
    for (int i = 0; i < 150; i++) begin
      send_beat(rand_data());
      if ($urandom_range(0, 2) == 0) begin
        s_valid = 1'b0;
        @(posedge clk);
        #1;
      end
    end
    s_valid = 1'b0;

    // Long stall
    rdy_mode = 2;
    repeat (2) @(posedge clk);
    #1;
    send_beat(rand_data());
    s_valid = 1'b0;
    repeat (4) @(posedge clk);
    #1;
    rdy_mode = 0;
    repeat (6) @(posedge clk);
    #1;

    check(sb_q.size() == 0, "R6 all delivered", OUT_W'(sb_q.size()), '0);
    check(!lane_valid, "R8 idle", {{(OUT_W-1){1'b0}}, lane_valid}, '0);
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule